// File: doc/BRIEF.md
# Serial Output Router with Fault Flag

This block decides what appears on three serial outputs of a transmit path: the main line output, a loopback output used for link self-test, and an auxiliary output. Each output is taken from one of four sources: the bit stream from the serializer, an external serial input that is passed straight through, a sample of the bit clock, or a constant low. Four static select inputs pick the route. The routed values are retimed through one register stage.

Beside the router sits a fault flag for an optical module. A rising edge on the laser alarm input sets the flag. A falling edge on the fault-clear input clears it. Both inputs are asynchronous to the block, so each passes through a synchronizer chain before edge detection. If a set edge and a clear edge are seen in the same cycle, the clear takes precedence.

Top module: `link_out_router`

## Requirements
- R1: With main output disable low, `main_out` carries `ext_serial` when `pass_sel` is 1 and `ser_data` when `pass_sel` is 0.
- R2: With `main_dis` at 1, `main_out` is 0 whatever the other inputs are.
- R3: With `loop_en` at 1, `loop_out` carries the source that R1 selects. With `loop_en` at 0, `loop_out` is 0. `main_dis` has no effect on `loop_out`.
- R4: With `aux_data_sel` at 0, `aux_out` carries `bit_clk_smp` whatever the other selects are.
- R5: With `aux_data_sel` at 1, `aux_out` is 0 when `pass_sel` is 0, and carries `ser_data` when `pass_sel` is 1.
- R6: The three routed outputs are registered. Each reflects the inputs sampled at the previous rising clock edge.
- R7: A 0-to-1 transition on `laser_alarm` sets `fault` to 1.
- R8: A 1-to-0 transition on `fault_clr` clears `fault` to 0, even while `laser_alarm` stays at 1.
- R9: `fault` holds its value when `laser_alarm` falls, when `fault_clr` rises, and while both inputs are steady.
- R10: When an alarm rising edge and a clear falling edge are detected in the same cycle, `fault` becomes 0.
- R11: After reset all outputs are 0. Each of `laser_alarm` and `fault_clr` passes through `SYNC_STAGES` flops. A change on either input therefore reaches `fault` at the (`SYNC_STAGES`+1)-th rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_data | input | 1 | Bit from the serializer |
| ext_serial | input | 1 | External serial input for pass-through |
| bit_clk_smp | input | 1 | Sample of the transmit bit clock |
| aux_data_sel | input | 1 | 0: bit clock on aux output; 1: data or low on aux output |
| pass_sel | input | 1 | 1: pass-through source; 0: serializer source |
| loop_en | input | 1 | Loopback output enable |
| main_dis | input | 1 | Forces the main output low |
| laser_alarm | input | 1 | Laser alarm; rising edge sets the fault flag |
| fault_clr | input | 1 | Fault clear; falling edge clears the fault flag |
| main_out | output | 1 | Main serial output |
| loop_out | output | 1 | Loopback serial output |
| aux_out | output | 1 | Auxiliary output |
| fault | output | 1 | Fault flag |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. This makes the fault latency a fixed three edges, so the bench can test the cycle one edge before the flag moves as well as the cycle in which it moves. The routing is swept over all 128 combinations of the four selects and the three data sources, and each combination is compared with the table computed in the bench. The fault sequence steps through every ordering of edges: set, hold on each inactive edge, clear while the alarm is still high, and a set and a clear arriving together.

// File: rtl/link_out_router_pkg.sv
package link_out_router_pkg;

    typedef struct packed {
        logic main;
        logic loop;
        logic aux;
    } route_t;

    localparam route_t ROUTE_IDLE = '{main: 1'b0, loop: 1'b0, aux: 1'b0};

endpackage

// File: rtl/route_select.sv
module route_select
    import link_out_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ext_serial,
    input  logic bit_clk_smp,
    input  logic aux_data_sel,
    input  logic pass_sel,
    input  logic loop_en,
    input  logic main_dis,
    output logic main_out,
    output logic loop_out,
    output logic aux_out
);

    route_t route_d, route_q;
    logic   src_bit;

    always_comb begin
        src_bit       = pass_sel ? ext_serial : ser_data;
        route_d       = ROUTE_IDLE;
        route_d.main  = main_dis ? 1'b0 : src_bit;
        route_d.loop  = loop_en ? src_bit : 1'b0;
        if (!aux_data_sel) begin
            route_d.aux = bit_clk_smp;
        end else begin
            route_d.aux = pass_sel ? ser_data : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= ROUTE_IDLE;
        end else begin
            route_q <= route_d;
        end
    end

    assign main_out = route_q.main;
    assign loop_out = route_q.loop;
    assign aux_out  = route_q.aux;

    AST_MAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_dis && pass_sel) |=> (main_out == $past(ext_serial))); // R1
    AST_MAIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        main_dis |=> !main_out); // R2
    AST_LOOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !loop_out); // R3
    AST_AUX_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_data_sel |=> (aux_out == $past(bit_clk_smp))); // R4
    AST_AUX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_data_sel && !pass_sel) |=> !aux_out); // R5

endmodule

// File: rtl/fault_edge_latch.sv
module fault_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_in,
    input  logic clear_in,
    output logic fault_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] alm_sh;
        logic [LAST:0] clr_sh;
        logic          alm_prev;
        logic          clr_prev;
        logic          flag;
    } fstate_t;

    fstate_t       st_d, st_q;
    logic [LAST:0] alm_shift_n, clr_shift_n;
    logic          alm_rise, clr_fall;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign alm_shift_n = alarm_in;
            assign clr_shift_n = clear_in;
        end else begin : g_chain
            assign alm_shift_n = {st_q.alm_sh[LAST-1:0], alarm_in};
            assign clr_shift_n = {st_q.clr_sh[LAST-1:0], clear_in};
        end
    endgenerate

    always_comb begin
        alm_rise      = st_q.alm_sh[LAST] & ~st_q.alm_prev;
        clr_fall      = ~st_q.clr_sh[LAST] & st_q.clr_prev;
        st_d          = st_q;
        st_d.alm_sh   = alm_shift_n;
        st_d.clr_sh   = clr_shift_n;
        st_d.alm_prev = st_q.alm_sh[LAST];
        st_d.clr_prev = st_q.clr_sh[LAST];
        if (clr_fall) begin
            st_d.flag = 1'b0;
        end else if (alm_rise) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.flag;

    initial begin
        AST_STAGES_VALID: assert (SYNC_STAGES >= 1); // R11
    end

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_rise && !clr_fall) |=> fault_o); // R7
    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall && !alm_rise) |=> !fault_o); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_rise && !clr_fall) |=> $stable(fault_o)); // R9
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_rise && clr_fall) |=> !fault_o); // R10

endmodule

// File: rtl/link_out_router.sv
module link_out_router #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ext_serial,
    input  logic bit_clk_smp,
    input  logic aux_data_sel,
    input  logic pass_sel,
    input  logic loop_en,
    input  logic main_dis,
    input  logic laser_alarm,
    input  logic fault_clr,
    output logic main_out,
    output logic loop_out,
    output logic aux_out,
    output logic fault
);

    route_select u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_data     (ser_data),
        .ext_serial   (ext_serial),
        .bit_clk_smp  (bit_clk_smp),
        .aux_data_sel (aux_data_sel),
        .pass_sel     (pass_sel),
        .loop_en      (loop_en),
        .main_dis     (main_dis),
        .main_out     (main_out),
        .loop_out     (loop_out),
        .aux_out      (aux_out)
    );

    fault_edge_latch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_in (laser_alarm),
        .clear_in (fault_clr),
        .fault_o  (fault)
    );

endmodule

// File: tb/link_out_router_test.sv
module link_out_router_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ext_serial = 1'b0, bit_clk_smp = 1'b0;
    logic aux_data_sel = 1'b0, pass_sel = 1'b0, loop_en = 1'b0, main_dis = 1'b0;
    logic laser_alarm = 1'b0, fault_clr = 1'b0;
    logic main_out, loop_out, aux_out, fault;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    link_out_router #(.SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ext_serial(ext_serial),
        .bit_clk_smp(bit_clk_smp), .aux_data_sel(aux_data_sel), .pass_sel(pass_sel),
        .loop_en(loop_en), .main_dis(main_dis), .laser_alarm(laser_alarm),
        .fault_clr(fault_clr), .main_out(main_out), .loop_out(loop_out),
        .aux_out(aux_out), .fault(fault)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic fault_step(input logic alm, input logic clr, input logic exp, input string req);
        @(negedge clk);
        laser_alarm = alm;
        fault_clr   = clr;
        edges(4);
        check(req, fault, exp);
    endtask

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        edges(2);
        check("R11 fault reset", fault, 1'b0);
        check("R11 main reset", main_out, 1'b0);
        check("R11 loop reset", loop_out, 1'b0);
        check("R11 aux reset", aux_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        edges(2);

        // Exhaustive routing sweep: R1 R2 R3 R4 R5
        for (int v = 0; v < 128; v++) begin
            logic e_src, e_main, e_loop, e_aux;
            @(negedge clk);
            aux_data_sel = v[0];
            pass_sel     = v[1];
            loop_en      = v[2];
            main_dis     = v[3];
            ser_data     = v[4];
            ext_serial   = v[5];
            bit_clk_smp  = v[6];
            e_src  = v[1] ? v[5] : v[4];
            e_main = v[3] ? 1'b0 : e_src;
            e_loop = v[2] ? e_src : 1'b0;
            e_aux  = !v[0] ? v[6] : (v[1] ? v[4] : 1'b0);
            edges(1);
            check(v[3] ? "R2 main disabled" : "R1 main source", main_out, e_main);
            check("R3 loop routing", loop_out, e_loop);
            check(v[0] ? "R5 aux data" : "R4 aux clock", aux_out, e_aux);
        end

        // R6: output changes only at the next rising edge
        @(negedge clk);
        aux_data_sel = 1'b1; pass_sel = 1'b1; loop_en = 1'b1; main_dis = 1'b0;
        ser_data = 1'b0; ext_serial = 1'b0;
        edges(1);
        check("R6 settle", main_out, 1'b0);
        @(negedge clk);
        ext_serial = 1'b1;
        #1;
        check("R6 before edge", main_out, 1'b0);
        edges(1);
        check("R6 after edge", main_out, 1'b1);

        // Fault latch: R11 latency, R7 set
        @(negedge clk);
        laser_alarm = 1'b1;
        edges(2);
        check("R11 no change after two edges", fault, 1'b0);
        edges(1);
        check("R7 set on alarm rise", fault, 1'b1);

        fault_step(1'b0, 1'b0, 1'b1, "R9 hold on alarm fall");
        fault_step(1'b0, 1'b1, 1'b1, "R9 hold on clear rise");
        fault_step(1'b1, 1'b1, 1'b1, "R7 alarm rise while set");
        fault_step(1'b1, 1'b0, 1'b0, "R8 clear while alarm high");
        fault_step(1'b1, 1'b1, 1'b0, "R9 hold on clear rise while clear");
        edges(3);
        check("R9 steady inputs", fault, 1'b0);
        fault_step(1'b0, 1'b1, 1'b0, "R9 alarm fall while clear");
        fault_step(1'b1, 1'b1, 1'b1, "R7 set again");
        fault_step(1'b0, 1'b1, 1'b1, "R9 hold before joint edges");
        fault_step(1'b1, 1'b0, 1'b0, "R10 clear wins over set");

        finish_run();
    end

endmodule